// File: doc/BRIEF.md
# Modulus Periodic Interval Timer

This block is a 16-bit down-counting interval timer. It sits behind a small synchronous register bus. Software programs a modulus value and sets a few control bits. On each count-enable tick the timer counts down. Each time the count reaches zero it raises a maskable interrupt flag. On the tick after that, the counter either reloads the modulus or wraps freely to 0xFFFF. An external single-cycle `tick` pulse stands in for the prescaled clock.

The modulus latch can work in two ways. It can hold a value only for the next reload. It can also be made transparent, so that every modulus write also replaces the live count at once. Reading the modulus register returns the latch contents. The live count is visible only through a separate read-only register.

The bus has three word registers, selected by address bits [3:2] with bits [1:0] at zero:

| Offset | Register |
|---|---|
| 0x0 | control |
| 0x4 | modulus |
| 0x8 | live count |

Any other address is ignored on writes and reads as 0.

Top module: `mpit_timer`

## Requirements
- R1: After reset, the control register reads 0, the modulus register reads 0x0000FFFF, the live-count register reads 0x0000FFFF, and `irq` is 0.
- R2: A write to the modulus register (offset 0x4) stores wdata[15:0] as the new modulus, and a read of that offset returns it. The read returns the latch, not the live count, and the upper 16 bits read as 0.
- R3: The live-count register (offset 0x8) returns the current count in bits [15:0] with zeros above. A write to it changes neither the count nor the modulus.
- R4: With the enable bit (control bit 0) at 0, ticks leave the count unchanged. With it at 1, each tick decrements a nonzero count by one.
- R5: The interrupt flag (control bit 2) becomes 1 on the tick that takes the count from 1 to 0. The flag is readable even when interrupts are masked. `irq` is 1 exactly when the flag and the interrupt-enable bit (control bit 3) are both 1.
- R6: With the reload bit (control bit 1) at 1, a tick while the count is 0 loads the count from the modulus latch.
- R7: With the reload bit at 0, a tick while the count is 0 sets the count to 0xFFFF.
- R8: With the overwrite bit (control bit 4) at 1, a modulus write also loads the written value into the count on the same edge. With it at 0, a modulus write leaves the count unchanged.
- R9: A control write with bit 2 at 1 clears the flag. A control write with bit 2 at 0 leaves the flag unchanged. The other control bits take the written values, and bits 31:5 read as 0.
- R10: Any write to the modulus register clears the flag.
- R11: When a flag-setting tick and a flag-clearing write fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high, 0 otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `addr`, `wdata` and the strobes are stable for the whole cycle they are sampled in. They also assume that `tick` is a clean one-cycle level at each clock edge. The bench keeps to this by changing every input only on the falling edge.

The flag properties also assume that a control write and a modulus write never arrive in the same cycle. A single address makes that impossible. The bench issues at most one write per cycle, with a tick merged in only where the set-versus-clear race is the point of the test.

// File: rtl/mpit_pkg.sv
package mpit_pkg;

    localparam int BIT_EN   = 0;
    localparam int BIT_RLD  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OVW  = 4;
    localparam int CTRL_W   = 5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_ALT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ovw;
        logic ie;
        logic rld;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/mpit_bus_decode.sv
module mpit_bus_decode
    import mpit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              wr_ctrl,
    output logic              wr_data,
    output reg_sel_e          sel
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        sel     = REG_NONE;
        if (aligned) begin
            if (word == WORD_W'(0))      sel = REG_CTRL;
            else if (word == WORD_W'(1)) sel = REG_DATA;
            else if (word == WORD_W'(2)) sel = REG_ALT;
        end
        wr_ctrl = wr_en && (sel == REG_CTRL);
        wr_data = wr_en && (sel == REG_DATA);
    end

endmodule

// File: rtl/mpit_ctrl_reg.sv
module mpit_ctrl_reg
    import mpit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic [CTRL_W-1:0] wbits,
    input  logic              hit_zero,
    output ctrl_t             ctrl,
    output logic              flag
);

    typedef struct packed {
        ctrl_t ctl;
        logic  flg;
    } cstate_t;

    cstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.ctl.en  = wbits[BIT_EN];
            s_d.ctl.rld = wbits[BIT_RLD];
            s_d.ctl.ie  = wbits[BIT_IE];
            s_d.ctl.ovw = wbits[BIT_OVW];
        end
        if ((wr_ctrl && wbits[BIT_FLAG]) || wr_data) begin
            s_d.flg = 1'b0;
        end
        if (hit_zero) begin
            s_d.flg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = s_q.ctl;
    assign flag = s_q.flg;

    // R11: a set event beats a same-cycle clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_zero |=> flag);

    // R9: write-one clears
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wbits[BIT_FLAG] && !hit_zero) |=> !flag);

    // R9: write-zero keeps the flag
    p_w0_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wbits[BIT_FLAG] && !hit_zero) |=> (flag == $past(flag)));

    // R10: a modulus write clears the flag
    p_data_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !hit_zero) |=> !flag);

endmodule

// File: rtl/mpit_counter.sv
module mpit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             rld,
    input  logic             ovw,
    input  logic             wr_data,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] modl;
        logic [CNT_W-1:0] cnt;
    } kstate_t;

    kstate_t s_d, s_q;
    logic    step;
    logic    load;
    logic    at_zero;

    always_comb begin
        step     = tick && en;
        load     = wr_data && ovw;
        at_zero  = (s_q.cnt == '0);
        hit_zero = 1'b0;
        s_d      = s_q;
        if (wr_data) begin
            s_d.modl = wval;
        end
        if (load) begin
            s_d.cnt = wval;
        end else if (step) begin
            if (at_zero) begin
                s_d.cnt = rld ? s_q.modl : ALL_ONES;
            end else begin
                s_d.cnt  = s_q.cnt - ONE;
                hit_zero = (s_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.modl <= ALL_ONES;
            s_q.cnt  <= ALL_ONES;
        end else begin
            s_q <= s_d;
        end
    end

    assign modulus = s_q.modl;
    assign count   = s_q.cnt;

    // R4: decrement by one per enabled tick
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !load && !at_zero) |=> (count == $past(count) - ONE));

    // R4: no counting while disabled
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_data) |=> $stable(count));

    // R6: reload from the latch
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !load && at_zero && rld) |=> (count == $past(modulus)));

    // R7: free wrap
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !load && at_zero && !rld) |=> (count == ALL_ONES));

    // R8: transparent latch overwrites the count
    p_ovw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(wval)));

    // R8: holding latch leaves the count alone
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !ovw && !(tick && en)) |=> $stable(count));

    // R2: modulus changes only on a data write
    p_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(modulus));

endmodule

// File: rtl/mpit_timer.sv
module mpit_timer
    import mpit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    logic             wr_ctrl;
    logic             wr_data;
    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic             flag;
    logic             hit_zero;
    logic [CNT_W-1:0] modulus;
    logic [CNT_W-1:0] count;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[BUS_W-1:CNT_W];

    mpit_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .sel     (sel)
    );

    mpit_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .wbits    (wdata[CTRL_W-1:0]),
        .hit_zero (hit_zero),
        .ctrl     (ctrl),
        .flag     (flag)
    );

    mpit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (ctrl.en),
        .rld      (ctrl.rld),
        .ovw      (ctrl.ovw),
        .wr_data  (wr_data),
        .wval     (wdata[CNT_W-1:0]),
        .modulus  (modulus),
        .count    (count),
        .hit_zero (hit_zero)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                REG_CTRL: begin
                    rdata[BIT_EN]   = ctrl.en;
                    rdata[BIT_RLD]  = ctrl.rld;
                    rdata[BIT_FLAG] = flag;
                    rdata[BIT_IE]   = ctrl.ie;
                    rdata[BIT_OVW]  = ctrl.ovw;
                end
                REG_DATA: rdata[CNT_W-1:0] = modulus;
                REG_ALT:  rdata[CNT_W-1:0] = count;
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = flag && ctrl.ie;

    // R5: an unmasked zero crossing raises irq on the next cycle
    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_zero && ctrl.ie && !wr_ctrl) |=> irq);

    // R5: masking lowers irq after a control write
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[BIT_IE]) |=> !irq);

endmodule

// File: tb/mpit_timer_bench.sv
`timescale 1ns/1ps
module mpit_timer_bench;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_DATA = 4'h4;
    localparam logic [3:0] A_ALT  = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #2 clk = ~clk;

    mpit_timer u_mpit_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;
    int    n_checks = 0;
    int    n_fail = 0;

    logic        m_en = 0, m_rld = 0, m_ie = 0, m_ovw = 0, m_flag = 0;
    logic [15:0] m_mod = 16'hFFFF, m_cnt = 16'hFFFF;

    always @(sample_ev) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
        end
    end

    task automatic cycle(input logic do_wr, input logic [3:0] a,
                         input logic [31:0] d, input logic do_tick);
        logic hit;
        logic wr_c, wr_d;
        @(negedge clk);
        wr_en = do_wr; rd_en = 1'b0; addr = a; wdata = d; tick = do_tick;
        @(posedge clk);
        wr_c = do_wr && (a == A_CTRL);
        wr_d = do_wr && (a == A_DATA);
        hit = 1'b0;
        if (wr_d && m_ovw) m_cnt = d[15:0];
        else if (do_tick && m_en) begin
            if (m_cnt == 16'h0) m_cnt = m_rld ? m_mod : 16'hFFFF;
            else begin
                hit = (m_cnt == 16'h1);
                m_cnt = m_cnt - 16'h1;
            end
        end
        if (wr_d) m_mod = d[15:0];
        if ((wr_c && d[2]) || wr_d) m_flag = 1'b0;
        if (hit) m_flag = 1'b1;
        if (wr_c) begin
            m_en = d[0]; m_rld = d[1]; m_ie = d[3]; m_ovw = d[4];
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'h0, 32'h0, 1'b1);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; rd_en = 1'b1; addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        #1;
        -> sample_ev;
        @(posedge clk);
    endtask

    task automatic check_all(input string tag);
        rd_chk(A_CTRL, {27'b0, m_ovw, m_ie, m_flag, m_rld, m_en}, {tag, " ctrl"});
        rd_chk(A_DATA, {16'b0, m_mod}, {tag, " data"});
        rd_chk(A_ALT,  {16'b0, m_cnt}, {tag, " alt"});
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        n_checks++;
        if (irq !== (m_flag && m_ie)) begin
            n_fail++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq, m_flag && m_ie);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        wr(A_DATA, 32'hABCD_0005);
        check_all("R2 R8 modulus write, holding latch");
        ticks(3);
        check_all("R4 disabled ticks hold");
        wr(A_CTRL, 32'h10);
        wr(A_DATA, 32'h3);
        check_all("R8 transparent latch load");
        wr(A_CTRL, 32'h13);
        ticks(1);
        check_all("R4 enabled decrement");
        ticks(2);
        check_all("R5 flag set, masked irq");
        ticks(1);
        check_all("R6 reload from latch");
        wr(A_CTRL, 32'h1B);
        check_all("R9 write-zero keeps flag, R5 irq");
        wr(A_CTRL, 32'h1F);
        check_all("R9 write-one clears");
        ticks(3);
        check_all("R5 second crossing");
        wr(A_DATA, 32'h7);
        check_all("R10 data write clears flag");
        wr(A_CTRL, 32'h19);
        wr(A_DATA, 32'h2);
        ticks(2);
        check_all("R7 reach zero, no reload");
        ticks(1);
        check_all("R7 wrap to FFFF");
        ticks(1);
        check_all("R4 decrement after wrap");
        wr(A_DATA, 32'h1);
        cycle(1'b1, A_CTRL, 32'h1D, 1'b1);
        check_all("R11 set beats clear");
        wr(A_ALT, 32'h1234);
        check_all("R3 alt write ignored");
        wr(A_CTRL, 32'h0B);
        wr(A_DATA, 32'h2);
        check_all("R8 holding latch keeps count, R10");
        ticks(1);
        check_all("R6 reload new modulus");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule